// File: doc/BRIEF.md
# SCSI Target Selection and Command Sequencer

This block is the target-side front end of a parallel SCSI bus port. Once the host arms it and gives it a bus ID, it watches the bus for a selection addressed to that ID. It answers the selection by driving BSY. It then takes one message-out byte if the initiator asked for one with ATN, and then collects the full command descriptor block. The host is not involved at any point in this sequence.

Every received byte goes out on a FIFO write port in the order it arrived. The sequencer learns the command length from the group code of the first command byte. When the last byte has been written, it raises a single interrupt that carries a status code. A byte with bad parity stops the sequence and is reported in the status code instead.

The host acknowledges the interrupt by dropping the arm input. This releases BSY and returns the block to idle.

Top module: `scsi_tgt_selcmd`

## Requirements
- R1: While `arm_en` is low, the block ignores any selection and `bus_bsy_out` stays low.
- R2: A selection is accepted only when `bus_sel` is high, `bus_bsy_in` is low, data bit `my_id` is set, and at most one other data bit is set. Any other bus pattern leaves `bus_bsy_out` low.
- R3: On an accepted selection, `bus_bsy_out` rises within a few cycles. No information phase starts until `bus_sel` has been released.
- R4: If `bus_atn` was high at selection, exactly one byte is taken in message-out phase (`bus_msg`=1, `bus_cd`=1, `bus_io`=0) before command phase. Otherwise command phase (`bus_msg`=0, `bus_cd`=1, `bus_io`=0) follows directly.
- R5: The command length is set by bits 7:5 of the first command byte: group 0 gives 6 bytes, groups 1 and 2 give 10, group 5 gives 12, and every other group gives 6.
- R6: Each byte uses an asynchronous handshake. `bus_req` rises only while `bus_ack` is low. Data is sampled when `bus_ack` is seen high, and `bus_req` falls on the next clock edge. The next `bus_req` waits until `bus_ack` is low again.
- R7: Each good byte, message then command, is written once with a one-cycle `fifo_wr` pulse, in the order it was received.
- R8: After the last command byte has been written, `irq` rises one cycle after that write, with `irq_code`=01. Both hold until `arm_en` falls. Then `irq` and `bus_bsy_out` clear.
- R9: Parity is odd over `bus_db` and `bus_dbp`. A byte with bad parity is not written, no further `bus_req` is issued, and `irq` rises with `irq_code`=10.
- R10: After reset, `bus_bsy_out`, `bus_req`, the phase lines, `fifo_wr` and `irq` are all low, and `irq_code` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_en | input | 1 | Host enable; dropping it acknowledges the interrupt |
| my_id | input | 3 | This target's bus ID |
| bus_sel | input | 1 | SEL from the bus |
| bus_bsy_in | input | 1 | BSY as seen on the bus, driven by others |
| bus_atn | input | 1 | ATN from the initiator |
| bus_ack | input | 1 | ACK from the initiator |
| bus_db | input | 8 | Bus data |
| bus_dbp | input | 1 | Bus data parity (odd) |
| bus_bsy_out | output | 1 | BSY driven by this target |
| bus_req | output | 1 | REQ to the initiator |
| bus_cd | output | 1 | Control/data phase line |
| bus_io | output | 1 | Direction phase line (always out to target here) |
| bus_msg | output | 1 | Message phase line |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| irq | output | 1 | Interrupt to the host |
| irq_code | output | 2 | 00 none, 01 command received, 10 parity error |

## Verification
The bench uses the default 8-bit bus. Because `my_id` is a port, every one of the eight target IDs can be reached at that width. Randomised sequences vary the target ID, an optional second ID bit, ATN, the command group and the byte values. As a result, all three command lengths and the group codes that fall back to six bytes are exercised. Directed cases cover rejected selections, and parity errors placed on the message byte and at random positions inside the command block.

// File: rtl/scsi_tgt_pkg.sv
// Shared types for the SCSI target sequencer.
// Holds the sequencer states, the interrupt status codes and the group-code decode.
package scsi_tgt_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SEL,
        SQ_MSGO,
        SQ_CMD,
        SQ_DONE
    } seq_state_t;

    localparam logic [1:0] IRQ_NONE    = 2'b00;
    localparam logic [1:0] IRQ_CMD_OK  = 2'b01;
    localparam logic [1:0] IRQ_PAR_ERR = 2'b10;

    localparam int CDB_MAX = 12;

    // Map a command group code to its descriptor length in bytes.
    function automatic logic [3:0] cdb_len(input logic [2:0] grp);
        case (grp)
            3'd0:       cdb_len = 4'd6;
            3'd1, 3'd2: cdb_len = 4'd10;
            3'd5:       cdb_len = 4'd12;
            default:    cdb_len = 4'd6;
        endcase
    endfunction

endpackage

// File: rtl/scsi_sel_match.sv
// Selection detector.
// Flags a valid selection of this target: the block is armed, SEL is high, BSY is low,
// the own ID bit is set and at most one other ID bit is set.
// Assumes the bus inputs are already synchronised to clk. Purely combinational.
module scsi_sel_match #(
    parameter int DW  = 8,
    localparam int IDW = $clog2(DW)
) (
    input  logic           armed,
    input  logic           sel,
    input  logic           bsy,
    input  logic [DW-1:0]  db,
    input  logic [IDW-1:0] id,
    output logic           hit
);
    // Count the asserted ID bits and test the own bit.
    always_comb begin
        hit = armed && sel && !bsy && db[id] && ($countones(db) <= 2);
    end
endmodule

// File: rtl/scsi_byte_rx.sv
// Target-side asynchronous byte receiver.
// While enabled it raises REQ, captures data and a parity flag when ACK is seen high,
// drops REQ, and pulses done once ACK has fallen.
// Assumes ACK is synchronised to clk. The enable must drop within the cycle after done.
module scsi_byte_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ack,
    input  logic [DW-1:0] db,
    input  logic          dbp,
    output logic          req,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr
);
    typedef enum logic [1:0] {RX_IDLE, RX_WAIT_HI, RX_WAIT_LO} rx_state_t;
    rx_state_t st;

    // Handshake state machine with captured byte and parity result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            req  <= 1'b0;
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (en && !done && !ack) begin
                        req <= 1'b1;
                        st  <= RX_WAIT_HI;
                    end
                end
                RX_WAIT_HI: begin
                    if (ack) begin
                        data <= db;
                        perr <= ~(^{db, dbp});
                        req  <= 1'b0;
                        st   <= RX_WAIT_LO;
                    end
                end
                RX_WAIT_LO: begin
                    if (!ack) begin
                        done <= 1'b1;
                        st   <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req); // R6
    AST_REQ_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !ack); // R6
endmodule

// File: rtl/scsi_tgt_selcmd.sv
// SCSI target selection and command sequencer (top).
// Once armed, it answers a selection of my_id and takes one message-out byte when ATN
// was set at selection. It then collects the command block, whose length comes from the
// group code, writes every good byte to the FIFO port, and raises one interrupt.
// Assumes all bus inputs are synchronised to clk and that the FIFO never fills.
module scsi_tgt_selcmd
    import scsi_tgt_pkg::*;
#(
    parameter int DW  = 8,
    localparam int IDW = $clog2(DW),
    localparam int CW  = $clog2(CDB_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm_en,
    input  logic [IDW-1:0] my_id,
    input  logic           bus_sel,
    input  logic           bus_bsy_in,
    input  logic           bus_atn,
    input  logic           bus_ack,
    input  logic [DW-1:0]  bus_db,
    input  logic           bus_dbp,
    output logic           bus_bsy_out,
    output logic           bus_req,
    output logic           bus_cd,
    output logic           bus_io,
    output logic           bus_msg,
    output logic           fifo_wr,
    output logic [DW-1:0]  fifo_wdata,
    output logic           irq,
    output logic [1:0]     irq_code
);
    seq_state_t     st;
    logic           sel_hit;
    logic           atn_r;
    logic [CW-1:0]  cnt;
    logic [3:0]     len_r;
    logic [3:0]     eff_len;
    logic           rx_en, rx_done, rx_perr;
    logic [DW-1:0]  rx_data;

    scsi_sel_match #(.DW(DW)) u_sel (
        .armed (arm_en),
        .sel   (bus_sel),
        .bsy   (bus_bsy_in),
        .db    (bus_db),
        .id    (my_id),
        .hit   (sel_hit)
    );

    scsi_byte_rx #(.DW(DW)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .ack   (bus_ack),
        .db    (bus_db),
        .dbp   (bus_dbp),
        .req   (bus_req),
        .done  (rx_done),
        .data  (rx_data),
        .perr  (rx_perr)
    );

    // Phase lines and receiver enable follow the sequencer state.
    always_comb begin
        rx_en   = (st == SQ_MSGO) || (st == SQ_CMD);
        bus_cd  = rx_en;
        bus_msg = (st == SQ_MSGO);
        bus_io  = 1'b0;
        eff_len = (cnt == '0) ? cdb_len(rx_data[DW-1 -: 3]) : len_r;
    end

    // Sequencer: selection, message-out, command collection, interrupt hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= SQ_IDLE;
            bus_bsy_out <= 1'b0;
            atn_r       <= 1'b0;
            cnt         <= '0;
            len_r       <= 4'd6;
            fifo_wr     <= 1'b0;
            fifo_wdata  <= '0;
            irq         <= 1'b0;
            irq_code    <= IRQ_NONE;
        end else begin
            fifo_wr <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (sel_hit) begin
                        bus_bsy_out <= 1'b1;
                        atn_r       <= bus_atn;
                        st          <= SQ_SEL;
                    end
                end
                SQ_SEL: begin
                    if (!bus_sel) begin
                        cnt <= '0;
                        st  <= atn_r ? SQ_MSGO : SQ_CMD;
                    end
                end
                SQ_MSGO: begin
                    if (rx_done) begin
                        if (rx_perr) begin
                            irq_code <= IRQ_PAR_ERR;
                            st       <= SQ_DONE;
                        end else begin
                            fifo_wr    <= 1'b1;
                            fifo_wdata <= rx_data;
                            st         <= SQ_CMD;
                        end
                    end
                end
                SQ_CMD: begin
                    if (rx_done) begin
                        if (rx_perr) begin
                            irq_code <= IRQ_PAR_ERR;
                            st       <= SQ_DONE;
                        end else begin
                            fifo_wr    <= 1'b1;
                            fifo_wdata <= rx_data;
                            cnt        <= cnt + 1'b1;
                            if (cnt == '0) len_r <= eff_len;
                            if ({{(4-CW+1){1'b0}}, cnt} + 5'd1 == {1'b0, eff_len}) begin
                                irq_code <= IRQ_CMD_OK;
                                st       <= SQ_DONE;
                            end
                        end
                    end
                end
                SQ_DONE: begin
                    if (!arm_en) begin
                        irq         <= 1'b0;
                        irq_code    <= IRQ_NONE;
                        bus_bsy_out <= 1'b0;
                        st          <= SQ_IDLE;
                    end else begin
                        irq <= 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    AST_DISARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && !arm_en) |=> (st == SQ_IDLE)); // R1
    AST_NO_PHASE_BEFORE_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_SEL && bus_sel) |=> !bus_cd); // R3
    AST_REQ_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_cd); // R4
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CDB_MAX)); // R5
    AST_WR_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> ($past(st) == SQ_MSGO || $past(st) == SQ_CMD)); // R7
    AST_IRQ_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && irq_code == IRQ_CMD_OK) |-> $past(fifo_wr)); // R8
    AST_PERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_perr) |=> !fifo_wr); // R9
endmodule

// File: tb/scsi_tgt_selcmd_bench.sv
`timescale 1ns/1ps
module scsi_tgt_selcmd_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       arm_en;
    logic [2:0] my_id;
    logic       bus_sel, bus_bsy_in, bus_atn, bus_ack, bus_dbp;
    logic [7:0] bus_db;
    logic       bus_bsy_out, bus_req, bus_cd, bus_io, bus_msg;
    logic       fifo_wr, irq;
    logic [7:0] fifo_wdata;
    logic [1:0] irq_code;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wr_total = 0;
    logic [7:0] got [0:255];

    always #2.5 clk = ~clk;

    scsi_tgt_selcmd u_scsi_tgt_selcmd (
        .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .my_id(my_id),
        .bus_sel(bus_sel), .bus_bsy_in(bus_bsy_in), .bus_atn(bus_atn),
        .bus_ack(bus_ack), .bus_db(bus_db), .bus_dbp(bus_dbp),
        .bus_bsy_out(bus_bsy_out), .bus_req(bus_req), .bus_cd(bus_cd),
        .bus_io(bus_io), .bus_msg(bus_msg), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .irq(irq), .irq_code(irq_code)
    );

    // Record every FIFO write.
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            got[wr_total % 256] = fifo_wdata;
            wr_total++;
        end
    end

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [2:0] g);
        if (g == 3'd5) return 12;
        if (g == 3'd1 || g == 3'd2) return 10;
        return 6;
    endfunction

    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic bus_idle();
        bus_sel = 0; bus_bsy_in = 0; bus_atn = 0; bus_ack = 0;
        bus_db = 8'h00; bus_dbp = 1'b1;
    endtask

    // One initiator byte transfer; checks phase lines and the REQ release.
    task automatic xfer(input logic [7:0] d, input bit bad, input bit in_msg);
        int w = 0;
        while (!bus_req && w < 60) begin @(negedge clk); w++; end
        chk(bus_req === 1'b1, "R6 req seen", bus_req, 1);
        chk({bus_msg, bus_cd, bus_io} === {in_msg, 1'b1, 1'b0}, "R4 phase lines",
            {bus_msg, bus_cd, bus_io}, {in_msg, 1'b1, 1'b0});
        bus_db = d;
        bus_dbp = bad ? ~odd_par(d) : odd_par(d);
        @(negedge clk);
        bus_ack = 1;
        @(negedge clk);
        chk(bus_req === 1'b0, "R6 req drop", bus_req, 0);
        @(negedge clk);
        bus_ack = 0;
        bus_db = 8'h00;
    endtask

    // Full selection and command sequence; badpos < 0 means no parity error.
    task automatic run_seq(input logic [2:0] id, input logic [7:0] other, input bit atn,
                           input logic [2:0] grp, input int badpos);
        logic [7:0] bytes [0:12];
        int n_msg, total, sent, exp_n, base, mism, w;
        n_msg = atn ? 1 : 0;
        total = n_msg + exp_len(grp);
        for (int i = 0; i < total; i++) bytes[i] = 8'($urandom);
        bytes[n_msg] = {grp, bytes[n_msg][4:0]};
        sent  = (badpos < 0) ? total : badpos + 1;
        exp_n = (badpos < 0) ? total : badpos;
        base  = wr_total;
        @(negedge clk);
        arm_en = 1; my_id = id;
        bus_db = (8'h01 << id) | other; bus_atn = atn; bus_sel = 1;
        w = 0;
        while (!bus_bsy_out && w < 10) begin @(negedge clk); w++; end
        chk(bus_bsy_out === 1'b1, "R3 bsy on selection", bus_bsy_out, 1);
        repeat (2) @(negedge clk);
        chk(bus_cd === 1'b0 && bus_req === 1'b0, "R3 wait for sel release", {bus_cd, bus_req}, 0);
        bus_sel = 0; bus_db = 8'h00;
        for (int k = 0; k < sent; k++) begin
            xfer(bytes[k], (k == badpos), (k < n_msg));
            if (k == 0) bus_atn = 0;
        end
        repeat (6) @(negedge clk);
        chk(wr_total - base == exp_n, "R5 R7 byte count", wr_total - base, exp_n);
        mism = 0;
        for (int i = 0; i < exp_n; i++) if (got[(base + i) % 256] !== bytes[i]) mism++;
        chk(mism == 0, "R7 byte order", mism, 0);
        chk(irq === 1'b1, "R8 irq raised", irq, 1);
        chk(irq_code === ((badpos < 0) ? 2'b01 : 2'b10), "R8 R9 irq code", irq_code,
            (badpos < 0) ? 2'b01 : 2'b10);
        chk(bus_req === 1'b0, "R9 no further req", bus_req, 0);
        arm_en = 0;
        repeat (3) @(negedge clk);
        chk(irq === 1'b0 && bus_bsy_out === 1'b0, "R8 clear on disarm", {irq, bus_bsy_out}, 0);
    endtask

    // Selection that must be ignored.
    task automatic no_sel(input bit armed, input logic [2:0] id, input logic [7:0] db,
                          input bit bsy, input string req);
        @(negedge clk);
        arm_en = armed; my_id = id; bus_db = db; bus_bsy_in = bsy; bus_sel = 1;
        repeat (6) @(negedge clk);
        chk(bus_bsy_out === 1'b0, req, bus_bsy_out, 0);
        bus_idle();
        arm_en = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 0; arm_en = 0; my_id = 0;
        bus_idle();
        repeat (4) @(negedge clk);
        chk({bus_bsy_out, bus_req, bus_cd, bus_io, bus_msg, fifo_wr, irq, irq_code} === 9'b0,
            "R10 reset state", {bus_bsy_out, bus_req, bus_cd, bus_io, bus_msg, fifo_wr, irq, irq_code}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1: disarmed; R2: wrong ID, too many bits, BSY busy.
        no_sel(1'b0, 3'd3, 8'h08, 1'b0, "R1 disarmed ignored");
        no_sel(1'b1, 3'd3, 8'h81, 1'b0, "R2 other id ignored");
        no_sel(1'b1, 3'd3, 8'h89, 1'b0, "R2 three bits ignored");
        no_sel(1'b1, 3'd3, 8'h08, 1'b1, "R2 busy bus ignored");

        // Directed: each length class, with and without message.
        run_seq(3'd0, 8'h00, 1'b0, 3'd0, -1);
        run_seq(3'd7, 8'h01, 1'b1, 3'd1, -1);
        run_seq(3'd2, 8'h00, 1'b0, 3'd2, -1);
        run_seq(3'd5, 8'h40, 1'b1, 3'd5, -1);
        run_seq(3'd1, 8'h00, 1'b0, 3'd7, -1);
        // R9: parity error on the message byte and on the last command byte.
        run_seq(3'd4, 8'h00, 1'b1, 3'd0, 0);
        run_seq(3'd6, 8'h00, 1'b0, 3'd5, 11);

        // Random sequences.
        for (int n = 0; n < 24; n++) begin
            logic [2:0] id, oid, grp;
            logic [7:0] other;
            bit atn;
            int bp, tot;
            id  = 3'($urandom);
            oid = 3'($urandom);
            other = ($urandom % 2) ? (8'h01 << oid) : 8'h00;
            atn = 1'($urandom);
            grp = 3'($urandom);
            tot = (atn ? 1 : 0) + exp_len(grp);
            bp  = ($urandom % 4 == 0) ? int'($urandom % tot) : -1;
            run_seq(id, other, atn, grp, bp);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule